// File: doc/BRIEF.md
# Multi-Level Page Table Walker with Reserved-Bit Faults

The walker turns a virtual address into a physical one by reading page-table entries through a single memory port, one entry per level. Two table layouts are supported. The long layout has four levels of 512 eight-byte entries. The three-level layout uses a four-entry pointer table and extended physical addresses. For every entry fetched, a classifier decides whether the entry is absent, breaks a reserved-bit rule, or may be followed. The set of reserved bits depends on the implemented physical width, the level, the layout and whether no-execute is enabled.

A host starts a walk by pulsing `start` with the address, the table root, the layout select, the no-execute enable, an address gate mask and the kind of access. The walker then issues reads, one at a time. Before it descends past an intermediate entry whose accessed flag is clear, it writes that entry back with the flag set. It finishes with a one-cycle `done` pulse. That pulse carries either the physical address with the combined permissions, or a fault flag with an error code that keeps reserved-bit faults apart from missing-entry faults.

Top module: `ptw_walker`

## Requirements
- R1: After reset `busy`, `done` and `mem_req` are low and remain low until `start` is seen.
- R2: An entry address is `((base & 0x000F_FFFF_FFFF_F000) + (idx << 3)) & gate_mask`, where `idx` is `va[47:39]`, `va[38:30]`, `va[29:21]` or `va[20:12]` for levels 3, 2, 1 and 0. The long-layout root uses `root[51:12]` with the level-3 index. The three-level root uses `root[51:5]` with index `va[31:30]`.
- R3: An entry with bit 0 clear ends the walk with `fault`=1 and a code whose bit 0 and bit 3 are 0. This outcome holds even if reserved bits are also set.
- R4: An entry with any bit set between the implemented physical width and bit 51 gives a reserved fault. The width is `LONG_PHYS_W` (40) in the long layout and `PAE_PHYS_W` (36) in the three-level layout. A reserved fault code has bit 0 and bit 3 set.
- R5: In the long layout, a level-3 entry with bit 7 set gives a reserved fault.
- R6: An entry at any level with bit 63 set while `nx_en`=0 gives a reserved fault. In the long layout with `nx_en`=1 the bit is accepted and sets `perm_xd`.
- R7: In the three-level layout, bits 62:52 and bit 63 are reserved at every level, whatever `nx_en` is.
- R8: An intermediate entry that passes its checks with bit 5 clear is written back to its own address as `entry | 0x20` before the next read. The leaf entry is never written.
- R9: On success, `phys_addr` = `{leaf[51:12], va[11:0]}`. `perm_w` and `perm_u` are the AND of bits 1 and 2 of the entries walked; the three-level pointer entry is left out of this AND. `perm_xd` is the OR of bit 63 of the entries walked when `nx_en`=1.
- R10: `done` lasts one cycle. `mem_req` stays high with `mem_addr` and `mem_we` stable until `mem_valid`, and only one access is outstanding at a time.
- R11: The layout, `nx_en`, the gate mask and the access kind are captured at `start`. Changing them during a walk does not change the result.
- R12: Fault code bit 1 equals the `acc_write` input and bit 2 equals the `acc_user` input captured at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| va | input | 48 | Virtual address to translate |
| root | input | 52 | Table root physical address |
| pae_mode | input | 1 | 1 = three-level layout, 0 = four-level long layout |
| nx_en | input | 1 | No-execute enable |
| gate_mask | input | 52 | AND mask applied to every entry address |
| acc_write | input | 1 | Access is a write |
| acc_user | input | 1 | Access is from user level |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a fault |
| fault_code | output | 4 | [0] present, [1] write, [2] user, [3] reserved |
| phys_addr | output | 52 | Translated physical address |
| perm_w | output | 1 | Combined write permission |
| perm_u | output | 1 | Combined user permission |
| perm_xd | output | 1 | Combined execute-disable |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 52 | Access address |
| mem_wdata | output | 64 | Write data |
| mem_valid | input | 1 | Access completed (read data valid) |
| mem_rdata | input | 64 | Read data |

## Verification
Two checks can hit the same entry: an absent entry may also carry reserved or no-execute bits, and only the present-bit verdict may win. The bench provokes this by clearing bit 0 on entries that also hold page-size and high reserved bits, and by random injection of several faults into one entry. A reference walk in the bench decides the winner, and the error code's reserved bit must stay 0 for such entries. A second overlap is an accessed-flag write-back followed by a read of the next level. There the bench counts writes and rereads memory to confirm that the flags were set on intermediate entries only.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   localparam int ENT_W   = 64;
   localparam int PA_W    = 52;
   localparam int VA_W    = 48;
   localparam int IDX_W   = 9;
   localparam int B_PRES  = 0;
   localparam int B_RW    = 1;
   localparam int B_US    = 2;
   localparam int B_ACC   = 5;
   localparam int B_PS    = 7;
   localparam int B_NX    = 63;

   typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_CHECK, ST_WBACK} walk_state_e;
   typedef enum logic [1:0] {CL_OK, CL_ABSENT, CL_RSVD} ent_class_e;

   // bits from phys_w up to 51 inside the table-address field
   function automatic logic [ENT_W-1:0] above_width_mask(input int phys_w);
      logic [ENT_W-1:0] m;
      m = '0;
      for (int b = 12; b < PA_W; b++) m[b] = (b >= phys_w);
      return m;
   endfunction

   function automatic logic [IDX_W-1:0] level_index(input logic [1:0] lvl,
                                                    input logic [VA_W-1:0] v);
      case (lvl)
         2'd3:    return v[47:39];
         2'd2:    return v[38:30];
         2'd1:    return v[29:21];
         default: return v[20:12];
      endcase
   endfunction
endpackage

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
   import ptw_pkg::*;
#(
   parameter int LONG_PHYS_W = 40,
   parameter int PAE_PHYS_W  = 36,
   parameter bit TOP_PS_RSVD = 1'b1
) (
   input  logic [ENT_W-1:0] entry,
   input  logic [1:0]       lvl,
   input  logic             pae,
   input  logic             nxe,
   output ent_class_e       cls
);
   localparam logic [ENT_W-1:0] HI_LONG  = above_width_mask(LONG_PHYS_W);
   localparam logic [ENT_W-1:0] HI_PAE   = above_width_mask(PAE_PHYS_W);
   localparam logic [ENT_W-1:0] PAE_WIDE = HI_PAE | {1'b1, 11'h7FF, 52'h0};

   generate
      if (LONG_PHYS_W < 32 || LONG_PHYS_W > PA_W) begin : g_bad_long
         $error("LONG_PHYS_W out of range");
      end
      if (PAE_PHYS_W < 32 || PAE_PHYS_W > LONG_PHYS_W) begin : g_bad_pae
         $error("PAE_PHYS_W out of range");
      end
   endgenerate

   logic [ENT_W-1:0] top_extra;
   generate
      if (TOP_PS_RSVD) begin : g_ps_top
         assign top_extra = (lvl == 2'd3) ? (ENT_W'(1) << B_PS) : '0;
      end else begin : g_no_ps_top
         assign top_extra = '0;
      end
   endgenerate

   logic [ENT_W-1:0] rsvd_mask;
   logic             nx_bad, rsvd_hit;

   always_comb begin
      rsvd_mask = pae ? PAE_WIDE : (HI_LONG | top_extra);
      nx_bad    = entry[B_NX] & ~nxe;
      rsvd_hit  = (|(entry & rsvd_mask)) | nx_bad;
      if (!entry[B_PRES])  cls = CL_ABSENT;
      else if (rsvd_hit)   cls = CL_RSVD;
      else                 cls = CL_OK;
   end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
   import ptw_pkg::*;
(
   input  logic [PA_W-1:5]  base,
   input  logic [IDX_W-1:0] idx,
   input  logic             pae_root,
   input  logic [PA_W-1:0]  gate,
   output logic [PA_W-1:0]  addr
);
   logic [PA_W-1:0] base_al;
   logic [PA_W-1:0] offs;

   always_comb begin
      base_al = pae_root ? {base[PA_W-1:5], 5'b0} : {base[PA_W-1:12], 12'b0};
      offs    = {{(PA_W-IDX_W-3){1'b0}}, idx, 3'b000};
      addr    = (base_al + offs) & gate;
   end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int LONG_PHYS_W = 40,
   parameter int PAE_PHYS_W  = 36
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [47:0]      va,
   input  logic [51:0]      root,
   input  logic             pae_mode,
   input  logic             nx_en,
   input  logic [51:0]      gate_mask,
   input  logic             acc_write,
   input  logic             acc_user,
   output logic             busy,
   output logic             done,
   output logic             fault,
   output logic [3:0]       fault_code,
   output logic [51:0]      phys_addr,
   output logic             perm_w,
   output logic             perm_u,
   output logic             perm_xd,
   output logic             mem_req,
   output logic             mem_we,
   output logic [51:0]      mem_addr,
   output logic [63:0]      mem_wdata,
   input  logic             mem_valid,
   input  logic [63:0]      mem_rdata
);
   walk_state_e      state_q;
   logic [1:0]       lvl_q;
   logic [VA_W-1:0]  va_q;
   logic             pae_q, nxe_q, wr_q, us_q;
   logic [PA_W-1:0]  gate_q, addr_q;
   logic [ENT_W-1:0] ent_q;
   logic             pw_q, pu_q, pxd_q, done_q, fault_q;
   logic [3:0]       code_q;
   logic [PA_W-1:0]  pa_q;

   logic [PA_W-1:0]  root_addr, next_addr;
   logic [IDX_W-1:0] root_idx;
   logic [1:0]       lvl_dn;
   ent_class_e       cls;

   assign root_idx = pae_mode ? {7'b0, va[31:30]} : level_index(2'd3, va);
   assign lvl_dn   = lvl_q - 2'd1;

   ptw_addr_gen u_root_gen (
      .base(root[PA_W-1:5]), .idx(root_idx), .pae_root(pae_mode),
      .gate(gate_mask), .addr(root_addr)
   );

   ptw_addr_gen u_next_gen (
      .base(ent_q[PA_W-1:5]), .idx(level_index(lvl_dn, va_q)), .pae_root(1'b0),
      .gate(gate_q), .addr(next_addr)
   );

   ptw_entry_check #(
      .LONG_PHYS_W(LONG_PHYS_W), .PAE_PHYS_W(PAE_PHYS_W), .TOP_PS_RSVD(1'b1)
   ) u_check (
      .entry(ent_q), .lvl(lvl_q), .pae(pae_q), .nxe(nxe_q), .cls(cls)
   );

   logic pointer_lvl;
   assign pointer_lvl = pae_q && (lvl_q == 2'd2);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         lvl_q   <= '0;
         va_q    <= '0;
         pae_q   <= 1'b0;
         nxe_q   <= 1'b0;
         wr_q    <= 1'b0;
         us_q    <= 1'b0;
         gate_q  <= '0;
         addr_q  <= '0;
         ent_q   <= '0;
         pw_q    <= 1'b0;
         pu_q    <= 1'b0;
         pxd_q   <= 1'b0;
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         code_q  <= '0;
         pa_q    <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (start) begin
               va_q    <= va;
               pae_q   <= pae_mode;
               nxe_q   <= nx_en;
               wr_q    <= acc_write;
               us_q    <= acc_user;
               gate_q  <= gate_mask;
               lvl_q   <= pae_mode ? 2'd2 : 2'd3;
               addr_q  <= root_addr;
               pw_q    <= 1'b1;
               pu_q    <= 1'b1;
               pxd_q   <= 1'b0;
               state_q <= ST_READ;
            end
            ST_READ: if (mem_valid) begin
               ent_q   <= mem_rdata;
               state_q <= ST_CHECK;
            end
            ST_CHECK: begin
               case (cls)
                  CL_ABSENT: begin
                     fault_q <= 1'b1;
                     code_q  <= {1'b0, us_q, wr_q, 1'b0};
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end
                  CL_RSVD: begin
                     fault_q <= 1'b1;
                     code_q  <= {1'b1, us_q, wr_q, 1'b1};
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end
                  default: begin
                     if (!pointer_lvl) begin
                        pw_q <= pw_q & ent_q[B_RW];
                        pu_q <= pu_q & ent_q[B_US];
                     end
                     if (nxe_q) pxd_q <= pxd_q | ent_q[B_NX];
                     if (lvl_q == 2'd0) begin
                        fault_q <= 1'b0;
                        code_q  <= '0;
                        pa_q    <= {ent_q[PA_W-1:12], va_q[11:0]};
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                     end else if (!ent_q[B_ACC]) begin
                        state_q <= ST_WBACK;
                     end else begin
                        addr_q  <= next_addr;
                        lvl_q   <= lvl_dn;
                        state_q <= ST_READ;
                     end
                  end
               endcase
            end
            ST_WBACK: if (mem_valid) begin
               addr_q  <= next_addr;
               lvl_q   <= lvl_dn;
               state_q <= ST_READ;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (state_q != ST_IDLE);
   assign done       = done_q;
   assign fault      = fault_q;
   assign fault_code = code_q;
   assign phys_addr  = pa_q;
   assign perm_w     = pw_q;
   assign perm_u     = pu_q;
   assign perm_xd    = pxd_q;
   assign mem_req    = (state_q == ST_READ) || (state_q == ST_WBACK);
   assign mem_we     = (state_q == ST_WBACK);
   assign mem_addr   = addr_q;
   assign mem_wdata  = ent_q | (ENT_W'(1) << B_ACC);

   // R1: no memory traffic while idle
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   // R10: request held steady until acknowledged
   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R10: completion is a single-cycle pulse
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4: a reserved fault always reports the entry as present
   p_rsvd_present_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault && fault_code[3]) |-> fault_code[0]);

   // R8: write-back targets the address that was just read
   p_wb_same_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we) |-> $stable(mem_addr));

   // R7: three-level layout never yields execute-disable
   p_pae_no_xd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault && pae_q) |-> !perm_xd);
endmodule

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [47:0] va = '0;
   logic [51:0] root = '0;
   logic        pae_mode = 1'b0;
   logic        nx_en = 1'b0;
   logic [51:0] gate_mask = '1;
   logic        acc_write = 1'b0;
   logic        acc_user = 1'b0;
   logic        busy, done, fault, perm_w, perm_u, perm_xd;
   logic [3:0]  fault_code;
   logic [51:0] phys_addr, mem_addr;
   logic        mem_req, mem_we;
   logic [63:0] mem_wdata;
   logic        mem_valid = 1'b0;
   logic [63:0] mem_rdata = '0;

   always #5 clk = ~clk;

   ptw_walker dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .va(va), .root(root),
      .pae_mode(pae_mode), .nx_en(nx_en), .gate_mask(gate_mask),
      .acc_write(acc_write), .acc_user(acc_user), .busy(busy), .done(done),
      .fault(fault), .fault_code(fault_code), .phys_addr(phys_addr),
      .perm_w(perm_w), .perm_u(perm_u), .perm_xd(perm_xd),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_valid(mem_valid), .mem_rdata(mem_rdata)
   );

   bit [63:0] mem [bit [51:0]];
   int        wr_cnt = 0;
   int        dly = 0;
   int        total = 0;
   int        bad = 0;
   bit        hung = 0;
   bit [51:0] lvl_addr [4];

   // memory responder: one access at a time, 0..2 wait cycles
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_valid <= 1'b0;
         dly       <= 0;
      end else if (mem_valid) begin
         mem_valid <= 1'b0;
      end else if (mem_req) begin
         if (dly == 0) begin
            mem_valid <= 1'b1;
            if (mem_we) begin
               mem[mem_addr] = mem_wdata;
               wr_cnt = wr_cnt + 1;
            end else begin
               mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
            end
            dly <= int'($urandom % 3);
         end else begin
            dly <= dly - 1;
         end
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic bit [8:0] vidx(input int l, input bit [47:0] v);
      case (l)
         3: return v[47:39];
         2: return v[38:30];
         1: return v[29:21];
         default: return v[20:12];
      endcase
   endfunction

   function automatic bit [51:0] m_addr(input bit [63:0] base, input int l,
         input bit pae, input bit is_root, input bit [47:0] v, input bit [51:0] g);
      bit [51:0] b, o;
      if (is_root && pae) begin
         b = {base[51:5], 5'b0};
         o = {47'b0, v[31:30], 3'b0};
      end else begin
         b = {base[51:12], 12'b0};
         o = {40'b0, vidx(l, v), 3'b0};
      end
      return (b + o) & g;
   endfunction

   // reference walk built from the requirements
   bit        e_fault, e_w, e_u, e_xd;
   bit [3:0]  e_code;
   bit [51:0] e_pa;
   int        e_nwr, e_nacc;
   bit [51:0] e_acc [4];
   string     e_tag;

   task automatic model(input bit pae, input bit nxe, input bit wr, input bit us,
                        input bit [47:0] v, input bit [51:0] rt, input bit [51:0] g);
      int l;
      bit [51:0] a;
      bit [63:0] e, msk;
      l = pae ? 2 : 3;
      a = m_addr({12'b0, rt}, l, pae, 1'b1, v, g);
      e_w = 1; e_u = 1; e_xd = 0; e_nwr = 0; e_nacc = 0; e_fault = 0;
      e_code = 0; e_pa = 0; e_tag = "R9";
      forever begin
         e = mem.exists(a) ? mem[a] : 64'h0;
         if (!e[0]) begin
            e_fault = 1; e_code = {1'b0, us, wr, 1'b0}; e_tag = "R3";
            break;
         end
         msk = pae ? 64'hFFFF_FFF0_0000_0000
                   : (64'h000F_FF00_0000_0000 | ((l == 3) ? 64'h80 : 64'h0));
         if ((e & msk) != 0 || (e[63] && !nxe)) begin
            e_fault = 1; e_code = {1'b1, us, wr, 1'b1};
            if (pae) e_tag = "R7";
            else if (e[63] && !nxe) e_tag = "R6";
            else if (l == 3 && e[7]) e_tag = "R5";
            else e_tag = "R4";
            break;
         end
         if (!(pae && l == 2)) begin
            e_w &= e[1];
            e_u &= e[2];
         end
         if (nxe) e_xd |= e[63];
         if (l == 0) begin
            e_pa = {e[51:12], v[11:0]};
            break;
         end
         if (!e[5]) begin
            e_nwr++;
            e_acc[e_nacc] = a;
            e_nacc++;
         end
         a = m_addr(e, l - 1, pae, 1'b0, v, g);
         l--;
      end
   endtask

   // builds one walk in memory; acc_mode 0 = random accessed flags, 1 = all clear
   task automatic build(input bit pae, input bit inject, input int acc_mode,
                        input bit [51:0] g, output bit [47:0] v, output bit [51:0] rt);
      int pw, l;
      bit [63:0] base, e, nb;
      bit [51:0] a;
      pw = pae ? 36 : 40;
      v = {$urandom, $urandom};
      if (pae) rt = {20'b0, $urandom} & ~52'h1F;
      else     rt = ({$urandom, $urandom} << 12) & 52'h00FF_FFFF_F000;
      base = {12'b0, rt};
      for (l = (pae ? 2 : 3); l >= 0; l--) begin
         a = m_addr(base, l, pae, (l == (pae ? 2 : 3)), v, g);
         nb = ({$urandom, $urandom} << 12) & ((64'h1 << pw) - 1);
         e = nb | 64'h1 | (64'(($urandom % 8) != 0) << 1) | (64'(($urandom % 8) != 0) << 2);
         if (acc_mode == 0) e |= 64'($urandom % 2) << 5;
         if (inject) begin
            case ($urandom % 40)
               0: e[0] = 1'b0;
               1: e[pw + int'($urandom % (52 - pw))] = 1'b1;
               2: e[7] = 1'b1;
               3: e[63] = 1'b1;
               4: e[52 + int'($urandom % 11)] = 1'b1;
               default: ;
            endcase
         end
         mem[a] = e;
         lvl_addr[l] = a;
         base = e;
      end
   endtask

   task automatic do_walk(input bit pae, input bit nxe, input bit [51:0] g,
                          input bit wr, input bit us, input bit [47:0] v,
                          input bit [51:0] rt, input bit flip);
      int n, w0;
      model(pae, nxe, wr, us, v, rt, g);
      w0 = wr_cnt;
      @(negedge clk);
      pae_mode = pae; nx_en = nxe; gate_mask = g; acc_write = wr; acc_user = us;
      va = v; root = rt; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (flip) begin  // R11: inputs changed after capture
         pae_mode = ~pae; nx_en = ~nxe; gate_mask = '0; acc_write = ~wr; acc_user = ~us;
         va = ~v; root = ~rt;
      end
      n = 0;
      while (!done && n < 4000) begin
         @(negedge clk);
         n++;
      end
      if (!done) begin
         bad++; total++; hung = 1;
         $display("FAIL R10 watchdog actual=busy expected=done");
         return;
      end
      chk(e_tag, "fault", fault, e_fault);
      if (e_fault) begin
         chk(e_tag, "code", fault_code, e_code);
         chk("R12", "code access bits", fault_code[2:1], {us, wr});
      end else begin
         chk("R9", "pa (R2 address path)", phys_addr, e_pa);
         chk("R9", "perm_w/u/xd", {perm_w, perm_u, perm_xd}, {e_w, e_u, e_xd});
      end
      @(negedge clk);
      chk("R10", "done pulse", done, 1'b0);
      chk("R8", "writeback count", wr_cnt - w0, e_nwr);
      for (int i = 0; i < e_nacc; i++)
         chk("R8", "accessed flag", mem[e_acc[i]][5], 1'b1);
   endtask

   initial begin
      bit [47:0] v;
      bit [51:0] rt;
      void'($urandom(32'h5EED_0042));
      repeat (5) @(negedge clk);
      chk("R1", "busy", busy, 1'b0);
      chk("R1", "done", done, 1'b0);
      chk("R1", "mem_req", mem_req, 1'b0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", "idle req", mem_req, 1'b0);

      // R3: absent top entry that also carries reserved bits
      build(0, 0, 0, '1, v, rt);
      mem[lvl_addr[3]] = (mem[lvl_addr[3]] & ~64'h1) | 64'h80 | (64'h1 << 45);
      do_walk(0, 1, '1, 1, 0, v, rt, 0);
      chk("R3", "absent wins", {fault, fault_code}, 5'b1_0010);

      // R5: page-size bit at top level
      build(0, 0, 0, '1, v, rt);
      mem[lvl_addr[3]] |= 64'h80;
      do_walk(0, 1, '1, 0, 1, v, rt, 0);
      chk("R5", "ps top", {fault, fault_code}, 5'b1_1101);

      // R4: bit 40 reserved in long layout, bit 39 allowed
      build(0, 0, 0, '1, v, rt);
      mem[lvl_addr[1]] |= 64'h1 << 40;
      do_walk(0, 1, '1, 0, 0, v, rt, 0);
      chk("R4", "bit40", {fault, fault_code[3]}, 2'b11);
      build(0, 0, 0, '1, v, rt);
      mem[lvl_addr[1]] |= 64'h1 << 39;
      do_walk(0, 1, '1, 0, 0, v, rt, 0);
      chk("R4", "bit39 ok", fault, 1'b0);

      // R6: NX leaf with and without enable
      build(0, 0, 0, '1, v, rt);
      mem[lvl_addr[0]] |= 64'h1 << 63;
      do_walk(0, 0, '1, 0, 0, v, rt, 0);
      chk("R6", "nx off", {fault, fault_code[3]}, 2'b11);
      do_walk(0, 1, '1, 0, 0, v, rt, 0);
      chk("R6", "nx on xd", {fault, perm_xd}, 2'b01);

      // R7: three-level widened mask
      build(1, 0, 0, '1, v, rt);
      mem[lvl_addr[1]] |= 64'h1 << 55;
      do_walk(1, 1, '1, 0, 0, v, rt, 0);
      chk("R7", "bit55", {fault, fault_code[3]}, 2'b11);
      build(1, 0, 0, '1, v, rt);
      mem[lvl_addr[0]] |= 64'h1 << 63;
      do_walk(1, 1, '1, 0, 0, v, rt, 0);
      chk("R7", "nx with enable", {fault, fault_code[3]}, 2'b11);
      build(1, 0, 0, '1, v, rt);
      mem[lvl_addr[2]] |= 64'h1 << 36;
      do_walk(1, 1, '1, 0, 0, v, rt, 0);
      chk("R4", "pae bit36", {fault, fault_code[3]}, 2'b11);

      // R8: every accessed flag clear
      build(0, 0, 1, '1, v, rt);
      do_walk(0, 1, '1, 0, 0, v, rt, 0);
      chk("R8", "three writes", e_nwr, 3);
      chk("R8", "leaf untouched", mem[lvl_addr[0]][5], 1'b0);

      // R2: gate mask clears bit 20
      build(0, 0, 0, 52'hF_FFFF_FFEF_FFFF, v, rt);
      do_walk(0, 1, 52'hF_FFFF_FFEF_FFFF, 0, 0, v, rt, 0);
      chk("R2", "gated walk", fault, 1'b0);

      // R11: inputs flipped mid-walk
      build(0, 0, 1, '1, v, rt);
      mem[lvl_addr[0]] |= 64'h1 << 63;
      do_walk(0, 1, '1, 1, 1, v, rt, 1);
      chk("R11", "captured nx", {fault, perm_xd}, 2'b01);

      for (int k = 0; k < 300 && !hung; k++) begin
         bit p;
         bit [51:0] g;
         p = ($urandom % 3) == 0;
         g = (($urandom % 8) == 0) ? 52'hF_FFFF_FFEF_FFFF : '1;
         build(p, 1, 0, g, v, rt);
         do_walk(p, 1'($urandom % 2), g, 1'($urandom % 2), 1'($urandom % 2), v, rt, 0);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      bad++; total++;
      $display("FAIL R10 global watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule